// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Level Masking

This block collects 32 external interrupt lines and presents a single interrupt request to the CPU. Each line has its own trigger mode: low-active, high-active, falling-edge or rising-edge. Each line also has its own 3-bit priority level. Edge-mode lines are synchronized and captured in sticky latches. Level-mode lines are pending for as long as the synchronized input is in its active state.

A programmable threshold masks every pending line whose level is not above it. Among the lines that remain, the controller picks the one with the highest level. A registered status word reports the winner's number and level, or reports that nothing is pending. Software clears an edge latch by writing a command word that names the line by number.

All registers sit behind a simple synchronous bus. The bus has a word address, a write strobe, write data, and read data that follows the address combinationally.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Word address 0, bit 0, is the global enable. While it is 0, `irq_out` stays low. The status word keeps reporting the arbitration result.
- R2: Trigger modes are 2 bits per line, coded as 00 low-active, 01 high-active, 10 falling-edge and 11 rising-edge. Line n uses word address 4 + n/16, bits (n mod 16)*2 +1 : (n mod 16)*2. All modes reset to 00.
- R3: Levels sit in the eight words at addresses 8 to 15. Line n uses address 8 + (n mod 16)/2, in an 8-bit slot starting at bit (n/16)*16 + (n mod 2)*8. The low 3 bits of the slot hold the level. A line at level 0 never wins.
- R4: Address 1, bits 2:0, hold the threshold. A pending line takes part in arbitration only when its level is strictly greater than the threshold.
- R5: The eligible line with the highest level wins. When levels are equal, the lowest line number wins.
- R6: The status word at address 3 carries the winner's number in bits 4:0 and its level in bits 10:8. When nothing is eligible, it reads exactly 0x0001_0000, with bit 16 set. Its reset value is 0x0001_0000.
- R7: An edge-mode line sets a sticky latch on its active transition, and the latch stays set after the input returns. A level-mode line is pending only while its input is active. A level change reaches the status word on the 3rd rising clock edge after the input changes. An edge reaches it on the 4th.
- R8: A write to address 2 with bit 8 set clears the edge latch of the line numbered in bits 4:0. A write with bit 8 clear changes nothing.
- R9: If an edge sets a latch on the same clock edge that a clear command names that line, the latch ends up set.
- R10: A mode write that changes a line's mode clears that line's edge latch. Rewriting the same mode leaves the latch as it is.
- R11: Address 2, addresses 6, 7 and 16 to 31, and all unused bits read as zero. The enable, threshold, mode and level registers reset to zero.
- R12: `irq_out` is a register. It rises and falls on the same clock edge as status bit 16 clears and sets, gated by the enable value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | External interrupt lines, asynchronous |
| bus_addr | input | 5 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
Two actions can land on the same edge latch on the same clock edge: a new active edge setting it, and a clear command removing it. A mode rewrite can also collide with an edge in the same way. The bench provokes the first collision by raising a rising-edge line and then issuing the clear command at a sweep of cycle offsets, so that one offset lands exactly on the setting edge. The status word read afterwards is compared with a behavioural model, and the exactly coincident offset is also checked against a fixed value. A random phase then toggles inputs while clear commands and threshold writes are issued, and the model judges `irq_out` on every clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_HIGH = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_RISE = 2'b11
   } trig_e;

   localparam int unsigned REG_EN        = 0;
   localparam int unsigned REG_THR       = 1;
   localparam int unsigned REG_CLR       = 2;
   localparam int unsigned REG_STAT      = 3;
   localparam int unsigned REG_MODE0     = 4;
   localparam int unsigned REG_LVL0      = 8;
   localparam int unsigned CLR_ARM_BIT   = 8;
   localparam int unsigned STAT_LVL_LSB  = 8;
   localparam int unsigned STAT_IDLE_BIT = 16;
   localparam int unsigned MODES_PER_REG = 16;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [1:0]   mode [N],
   input  logic [N-1:0] clr_req,
   input  logic [N-1:0] flush,
   output logic [N-1:0] pend,
   output logic [N-1:0] latch_o
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [N-1:0] sync1_q, sync2_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= '0;
         sync2_q <= '0;
         prev_q  <= '0;
      end else begin
         sync1_q <= irq_in;
         sync2_q <= sync1_q;
         prev_q  <= sync2_q;
      end
   end

   for (genvar k = 0; k < N; k++) begin : g_line
      logic edge_hit;
      logic lat_q;

      always_comb begin
         case (trig_e'(mode[k]))
            TRIG_RISE: edge_hit = sync2_q[k] & ~prev_q[k];
            TRIG_FALL: edge_hit = ~sync2_q[k] & prev_q[k];
            default:   edge_hit = 1'b0;
         endcase
      end

      // mode change beats a new edge; a new edge beats a clear command
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             lat_q <= 1'b0;
         else if (flush[k])      lat_q <= 1'b0;
         else if (edge_hit)      lat_q <= 1'b1;
         else if (clr_req[k])    lat_q <= 1'b0;
      end

      assign latch_o[k] = lat_q;
      assign pend[k]    = mode[k][1] ? lat_q
                        : (mode[k][0] ? sync2_q[k] : ~sync2_q[k]);
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int unsigned N     = 32,
   parameter int unsigned LVL_W = 3,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     pend,
   input  logic [LVL_W-1:0] lvl [N],
   input  logic [LVL_W-1:0] thr,
   output logic             found,
   output logic [IDX_W-1:0] win_idx,
   output logic [LVL_W-1:0] win_lvl
);
   timeunit 1ns;
   timeprecision 1ps;

   // scan from the top so that an equal level further down replaces the
   // current pick: the lowest index wins a tie
   always_comb begin
      found   = 1'b0;
      win_idx = '0;
      win_lvl = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i] && (lvl[i] > thr) && (!found || lvl[i] >= win_lvl)) begin
            found   = 1'b1;
            win_idx = IDX_W'(i);
            win_lvl = lvl[i];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_IN = 32,
   parameter int unsigned LVL_W  = 3,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] irq_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned IDX_W = $clog2(NUM_IN);

   if (NUM_IN != 16 && NUM_IN != 32) begin : g_bad_num
      $error("NUM_IN must be 16 or 32 for the packed register layout");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("LVL_W must fit an 8-bit slot");
   end
   if (DATA_W != 32 || ADDR_W < 4) begin : g_bad_bus
      $error("bus must be 32 bits wide with at least 16 word addresses");
   end

   logic              en_q;
   logic [LVL_W-1:0]  thr_q;
   logic [1:0]        mode_q [NUM_IN];
   logic [LVL_W-1:0]  lvl_q  [NUM_IN];
   logic [DATA_W-1:0] stat_q, stat_d;
   logic              irq_q;

   logic [NUM_IN-1:0] clr_req, flush, pend, edge_latch, is_edge;
   logic              found;
   logic [IDX_W-1:0]  win_idx;
   logic [LVL_W-1:0]  win_lvl;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata;

   wire wr_en  = bus_wr && (bus_addr == ADDR_W'(REG_EN));
   wire wr_thr = bus_wr && (bus_addr == ADDR_W'(REG_THR));
   wire wr_clr = bus_wr && (bus_addr == ADDR_W'(REG_CLR)) && bus_wdata[CLR_ARM_BIT];

   for (genvar k = 0; k < NUM_IN; k++) begin : g_cfg
      localparam int unsigned MREG = REG_MODE0 + k / MODES_PER_REG;
      localparam int unsigned MOFS = (k % MODES_PER_REG) * 2;
      localparam int unsigned LREG = REG_LVL0 + (k % 16) / 2;
      localparam int unsigned LOFS = (k / 16) * 16 + (k % 2) * 8;

      logic [1:0]       m_q;
      logic [LVL_W-1:0] l_q;
      wire  mode_hit = bus_wr && (bus_addr == ADDR_W'(MREG));
      wire  lvl_hit  = bus_wr && (bus_addr == ADDR_W'(LREG));
      wire  [1:0] new_mode = bus_wdata[MOFS +: 2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= 2'b00;
            l_q <= '0;
         end else begin
            if (mode_hit) m_q <= new_mode;
            if (lvl_hit)  l_q <= bus_wdata[LOFS +: LVL_W];
         end
      end

      assign mode_q[k]  = m_q;
      assign lvl_q[k]   = l_q;
      assign is_edge[k] = m_q[1];
      assign flush[k]   = mode_hit && (new_mode != m_q);
      assign clr_req[k] = wr_clr && (bus_wdata[4:0] == 5'(k));
   end

   irq_edge_detect #(.N(NUM_IN)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_in  (irq_in),
      .mode    (mode_q),
      .clr_req (clr_req),
      .flush   (flush),
      .pend    (pend),
      .latch_o (edge_latch)
   );

   irq_arbiter #(.N(NUM_IN), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
      .pend    (pend),
      .lvl     (lvl_q),
      .thr     (thr_q),
      .found   (found),
      .win_idx (win_idx),
      .win_lvl (win_lvl)
   );

   always_comb begin
      stat_d = '0;
      stat_d[STAT_IDLE_BIT] = !found;
      if (found) begin
         stat_d[IDX_W-1:0]               = win_idx;
         stat_d[STAT_LVL_LSB +: LVL_W]   = win_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         thr_q  <= '0;
         stat_q <= DATA_W'(1) << STAT_IDLE_BIT;
         irq_q  <= 1'b0;
      end else begin
         if (wr_en)  en_q  <= bus_wdata[0];
         if (wr_thr) thr_q <= bus_wdata[LVL_W-1:0];
         stat_q <= stat_d;
         irq_q  <= en_q && found;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(REG_EN))   bus_rdata[0]         = en_q;
      if (bus_addr == ADDR_W'(REG_THR))  bus_rdata[LVL_W-1:0] = thr_q;
      if (bus_addr == ADDR_W'(REG_STAT)) bus_rdata            = stat_q;
      for (int k = 0; k < NUM_IN; k++) begin
         if (bus_addr == ADDR_W'(REG_MODE0 + k / MODES_PER_REG))
            bus_rdata[(k % MODES_PER_REG) * 2 +: 2] = mode_q[k];
         if (bus_addr == ADDR_W'(REG_LVL0 + (k % 16) / 2))
            bus_rdata[(k / 16) * 16 + (k % 2) * 8 +: LVL_W] = lvl_q[k];
      end
   end

   assign irq_out = irq_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int unsigned N     = 32,
   parameter int unsigned LVL_W = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en_q,
   input logic         irq_q,
   input logic [31:0]  stat_q,
   input logic [N-1:0] latch,
   input logic [N-1:0] edge_mode
);
   timeunit 1ns;
   timeprecision 1ps;

   // R1
   irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !irq_q);

   // R12
   irq_implies_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> !stat_q[16]);

   // R3
   winner_level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_q[16] |-> (stat_q[8 +: LVL_W] != '0));

   // R6
   idle_status_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[16] |-> (stat_q[15:0] == 16'h0 && stat_q[31:17] == '0));

   // R10
   latch_only_in_edge_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch & ~edge_mode) == '0);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.N(NUM_IN), .LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en_q      (en_q),
   .irq_q     (irq_q),
   .stat_q    (stat_q),
   .latch     (edge_latch),
   .edge_mode (is_edge)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '1;
   logic [4:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(addr),
      .bus_wr(wr_en), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq_out)
   );

   // behavioural reference model
   int          m_mode [32];
   int          m_lvl  [32];
   int          m_thr;
   bit          m_en;
   logic [31:0] m_s1, m_s2, m_s3, m_lat, m_stat;
   bit          m_irq;

   always @(posedge clk or negedge rst_n) begin
      int best, bl, nm;
      bit p, set, clr, chg;
      if (!rst_n) begin
         foreach (m_mode[k]) begin m_mode[k] = 0; m_lvl[k] = 0; end
         m_thr = 0; m_en = 0; m_irq = 0;
         m_s1 = '0; m_s2 = '0; m_s3 = '0; m_lat = '0;
         m_stat = 32'h0001_0000;
      end else begin
         best = -1; bl = 0;
         for (int k = 0; k < 32; k++) begin
            p = (m_mode[k] >= 2) ? m_lat[k] : ((m_mode[k] == 1) ? m_s2[k] : !m_s2[k]);
            if (p && m_lvl[k] > m_thr && (best < 0 || m_lvl[k] > bl)) begin
               best = k; bl = m_lvl[k];
            end
         end
         m_stat = (best < 0) ? 32'h0001_0000 : ((bl << 8) | best);
         m_irq  = m_en && (best >= 0);
         for (int k = 0; k < 32; k++) begin
            nm  = (wdata >> ((k % 16) * 2)) & 3;
            chg = wr_en && addr == 4 + k / 16 && nm != m_mode[k];
            set = (m_mode[k] == 3 && m_s2[k] && !m_s3[k]) ||
                  (m_mode[k] == 2 && !m_s2[k] && m_s3[k]);
            clr = wr_en && addr == 2 && wdata[8] && wdata[4:0] == k;
            if (chg)      m_lat[k] = 1'b0;
            else if (set) m_lat[k] = 1'b1;
            else if (clr) m_lat[k] = 1'b0;
         end
         if (wr_en) begin
            if (addr == 0) m_en  = wdata[0];
            if (addr == 1) m_thr = wdata & 7;
            for (int k = 0; k < 32; k++) begin
               if (addr == 4 + k / 16) m_mode[k] = (wdata >> ((k % 16) * 2)) & 3;
               if (addr == 8 + (k % 16) / 2) m_lvl[k] = (wdata >> ((k / 16) * 16 + (k % 2) * 8)) & 7;
            end
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_in;
      end
   end

   function automatic logic [31:0] exp_rd(int a);
      logic [31:0] v = '0;
      if (a == 0) v[0] = m_en;
      if (a == 1) v = m_thr;
      if (a == 3) v = m_stat;
      for (int k = 0; k < 32; k++) begin
         if (a == 4 + k / 16) v |= m_mode[k] << ((k % 16) * 2);
         if (a == 8 + (k % 16) / 2) v |= m_lvl[k] << ((k / 16) * 16 + (k % 2) * 8);
      end
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // R12: irq_out against the model on every clock
   always @(negedge clk) if (rst_n && !done) chk("R12 irq_out", {31'b0, irq_out}, {31'b0, m_irq});

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      addr = 5'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(int a, string req);
      @(negedge clk);
      addr = 5'(a);
      #1;
      chk(req, rdata, exp_rd(a));
   endtask

   task automatic stat_is(string req, logic [31:0] exp);
      @(negedge clk);
      addr = 5'd3;
      #1;
      chk(req, rdata, exp);
      chk(req, rdata, m_stat);
   endtask

   initial begin
      #1_000_000;
      checks++; errors++;
      $display("FAIL R12 watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(2);
      // R11 / R6 reset state
      stat_is("R6 reset status", 32'h0001_0000);
      chk("R12 reset irq", {31'b0, irq_out}, 32'h0);
      for (int a = 0; a < 32; a++) rd_chk(a, "R11 reset read");

      wr(0, 1);
      // R2 low-active line 5, R3 level slot
      wr(10, 32'h0000_0300);
      irq_in[5] = 1'b0;
      idle(5);
      stat_is("R2 low-active line 5", 32'h0000_0305);

      // R5 higher level wins; tie goes to lower index
      wr(5, 32'h0000_0100);
      wr(10, 32'h0005_0300);
      irq_in[20] = 1'b1;
      idle(5);
      stat_is("R5 higher level", 32'h0000_0514);
      wr(5, 32'h0000_0500);
      wr(10, 32'h0505_0300);
      irq_in[21] = 1'b1;
      idle(5);
      stat_is("R5 tie lowest index", 32'h0000_0514);
      rd_chk(5, "R2 mode readback");
      chk("R2 mode word", exp_rd(5), 32'h0000_0500);

      // R4 threshold
      wr(1, 5);
      idle(3);
      stat_is("R4 all masked", 32'h0001_0000);
      chk("R4 irq low", {31'b0, irq_out}, 32'h0);
      wr(1, 2);
      idle(3);
      stat_is("R4 threshold 2", 32'h0000_0514);

      // R3 level zero disables
      wr(10, 32'h0500_0300);
      idle(3);
      stat_is("R3 level zero", 32'h0000_0515);
      rd_chk(10, "R3 level readback");

      // R7 rising edge sticky on line 9
      wr(4, 32'h000C_0000);
      wr(12, 32'h0000_0700);
      irq_in[9] = 1'b0; idle(4);
      irq_in[9] = 1'b1; idle(2);
      irq_in[9] = 1'b0; idle(5);
      stat_is("R7 sticky edge", 32'h0000_0709);

      // R8 clear command
      wr(2, 32'h0000_0009);
      idle(3);
      stat_is("R8 unarmed clear ignored", 32'h0000_0709);
      wr(2, 32'h0000_0109);
      idle(3);
      stat_is("R8 armed clear", 32'h0000_0515);

      // R9 edge against clear at swept offsets
      for (int d = 0; d < 5; d++) begin
         irq_in[9] = 1'b1;
         repeat (d) @(negedge clk);
         wr(2, 32'h0000_0109);
         idle(6);
         rd_chk(3, "R9 coincident clear");
         if (d == 1) chk("R9 set beats clear", exp_rd(3), 32'h0000_0709);
         wr(2, 32'h0000_0109);
         irq_in[9] = 1'b0;
         idle(5);
      end

      // R10 mode rewrite
      irq_in[9] = 1'b1; idle(2);
      irq_in[9] = 1'b0; idle(5);
      stat_is("R10 latched", 32'h0000_0709);
      wr(4, 32'h000C_0000);
      idle(3);
      stat_is("R10 same mode keeps", 32'h0000_0709);
      wr(4, 32'h0008_0000);
      idle(3);
      stat_is("R10 change flushes", 32'h0000_0515);
      // R2 falling edge
      irq_in[9] = 1'b1; idle(4);
      irq_in[9] = 1'b0; idle(5);
      stat_is("R2 falling edge", 32'h0000_0709);

      // R1 enable gate
      wr(0, 0);
      idle(2);
      chk("R1 disabled irq", {31'b0, irq_out}, 32'h0);
      stat_is("R1 status kept", 32'h0000_0709);
      wr(0, 1);
      idle(2);
      chk("R1 enabled irq", {31'b0, irq_out}, 32'h1);

      // R11 undefined and write-only addresses
      rd_chk(2, "R11 clear reads zero");
      rd_chk(6, "R11 hole");
      rd_chk(31, "R11 high address");
      chk("R11 hole value", exp_rd(6), 32'h0);

      // random phase: R7 R8 R9 R12
      wr(4, $urandom);
      wr(5, $urandom);
      for (int a = 8; a < 16; a++) wr(a, $urandom);
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         irq_in = irq_in ^ ($urandom & $urandom & $urandom);
         if ($urandom % 6 == 0) begin
            addr = 5'd2; wdata = 32'h100 | ($urandom % 32); wr_en = 1'b1;
         end else if ($urandom % 40 == 0) begin
            addr = 5'd1; wdata = $urandom % 8; wr_en = 1'b1;
         end else begin
            wr_en = 1'b0; addr = 5'd3;
            #1;
            chk("R7 random status", rdata, m_stat);
         end
      end
      wr_en = 1'b0;
      idle(2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule